// File: doc/BRIEF.md
# Low-Power-Stop Broadcast Cycle Sequencer

This block sits between a processor core and an external asynchronous bus. When the core executes its low-power-stop instruction it raises a stop request and presents its 3-bit interrupt mask. The block then asks for the bus and waits until the bus is granted. Once it owns the bus, it runs one write cycle in CPU space that carries the mask. Devices outside the chip can see this cycle and prepare for stop.

The block acknowledges the write itself, so no external device has to respond. After the strobes are negated, the block releases the bus. It then waits as long as the external halt input is asserted. Only when halt is low does it report to the core that stop mode is active. Stop-active stays set until the core pulses its wake input.

Top module: `stop_bcast_seq`

## Requirements
- R1: A synchronous active-high reset makes every output low, with one exception: `rw_o`, which reads high. After reset the block is idle.
- R2: A stop request seen at a clock edge while idle raises `bus_req` one cycle later. No strobe is asserted in any cycle where `bus_grant` was low at the preceding edge while the request was pending.
- R3: The first edge at which `bus_grant` is high while the request is pending asserts `as_o` and `ds_o` one cycle later. In every cycle where `as_o` is high, `rw_o` is 0 (write), `fc_o` is 3'b111 and `addr_o` equals 0x030000. That address is bits 19:16 set to 4'b0011, the type-3 code, with all other bits zero.
- R4: While the strobes are asserted, `data_o[2:0]` carries the interrupt mask, with bit 2 as the most significant mask bit. `data_o[15:3]` is zero and `data_oe` is high.
- R5: The mask is captured at the edge that accepts the request. Later changes on `mask` do not change `data_o`.
- R6: The cycle after the strobes first rise, the block asserts `dtack_int` for exactly one cycle while the strobes are still high. No external acknowledge is used.
- R7: The strobes fall the cycle after `dtack_int`. `bus_req` is held through that cycle and released on the next one.
- R8: `stop_active` rises no earlier than the second cycle after the bus is released. It rises only after an edge at which `halt` is low. While `halt` stays high, `stop_active` stays low.
- R9: Once set, `stop_active` stays high until an edge at which `wake` is high. Stop requests that arrive while it is set start no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Low-power-stop request from the core |
| mask | input | 3 | Interrupt mask level from the core |
| wake | input | 1 | Core wake pulse, clears stop-active |
| bus_grant | input | 1 | Bus ownership granted |
| halt | input | 1 | External hold-off, high delays stop entry |
| bus_req | output | 1 | Bus ownership request |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| rw_o | output | 1 | 1 = read, 0 = write |
| fc_o | output | 3 | Function code |
| addr_o | output | 24 | Address bus |
| data_o | output | 16 | Write data |
| data_oe | output | 1 | Data bus output enable |
| dtack_int | output | 1 | Internally generated transfer acknowledge |
| stop_active | output | 1 | Stop mode entered |

## Verification
Two conditions are hardest to reach from the ports. The first is a halt held high across several cycles right where the bus is released. The second is a grant that arrives late while the mask input changes under a pending request. The bench sweeps every mask value against grant delays of zero to two cycles and halt lengths of zero to three cycles. During each delay it flips the mask to its complement, and it times the halt to cover the wait state exactly. It also fires a stop request while stop-active is set and checks that the bus stays quiet.

// File: rtl/stop_bcast_seq.sv
module stop_bcast_seq #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int TYPE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic [2:0]        mask,
  input  logic              wake,
  input  logic              bus_grant,
  input  logic              halt,
  output logic              bus_req,
  output logic              as_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic [2:0]        fc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              dtack_int,
  output logic              stop_active
);
  localparam logic [ADDR_W-1:0] ADDR_T3 = ADDR_W'(4'b0011) << TYPE_LSB;

  typedef enum logic [2:0] {IDLE, REQ, STRB, ACK, NEG, HWAIT, STOP} st_t;
  st_t st;
  logic [2:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IDLE;
      mask_q <= '0;
    end else begin
      case (st)
        IDLE:  if (stop_req) begin st <= REQ; mask_q <= mask; end
        REQ:   if (bus_grant) st <= STRB;
        STRB:  st <= ACK;
        ACK:   st <= NEG;
        NEG:   st <= HWAIT;
        HWAIT: if (!halt) st <= STOP;
        STOP:  if (wake) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire strobe = (st == STRB) || (st == ACK);

  assign bus_req     = (st == REQ) || strobe || (st == NEG);
  assign as_o        = strobe;
  assign ds_o        = strobe;
  assign rw_o        = !strobe;
  assign fc_o        = strobe ? 3'b111 : 3'b000;
  assign addr_o      = strobe ? ADDR_T3 : '0;
  assign data_o      = strobe ? {{(DATA_W-3){1'b0}}, mask_q} : '0;
  assign data_oe     = strobe;
  assign dtack_int   = (st == ACK);
  assign stop_active = (st == STOP);

  // R2
  strb_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (st == REQ && !bus_grant) |=> !as_o);
  // R3
  cpu_space_chk: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (fc_o == 3'b111 && !rw_o && addr_o == ADDR_T3));
  // R6
  ack_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dtack_int |-> (as_o && ds_o && bus_req));
  // R7
  strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    dtack_int |=> (!as_o && bus_req));
  // R8
  halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !stop_active) |=> !stop_active);
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_active && !wake) |=> (stop_active && !bus_req));
endmodule

// File: tb/sim_stop_bcast_seq.sv
module sim_stop_bcast_seq;
  logic clk = 0, rst = 1, stop_req = 0, wake = 0, bus_grant = 0, halt = 0;
  logic [2:0] mask = 0;
  logic bus_req, as_o, ds_o, rw_o, data_oe, dtack_int, stop_active;
  logic [2:0] fc_o;
  logic [23:0] addr_o;
  logic [15:0] data_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stop_bcast_seq u0 (.clk, .rst, .stop_req, .mask, .wake, .bus_grant, .halt,
    .bus_req, .as_o, .ds_o, .rw_o, .fc_o, .addr_o, .data_o, .data_oe,
    .dtack_int, .stop_active);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(logic [2:0] m, int gd, int hl);
    @(negedge clk); stop_req = 1; mask = m; bus_grant = 0;
    @(negedge clk);
    chk("R2 bus_req", bus_req, 1); chk("R2 no strobe", as_o, 0);
    stop_req = 0; mask = ~m;
    for (int i = 0; i < gd; i++) begin
      @(negedge clk); chk("R2 wait grant", {bus_req, as_o}, 2'b10);
    end
    bus_grant = 1;
    @(negedge clk);
    chk("R3 strobes", {as_o, ds_o, rw_o}, 3'b110);
    chk("R3 fc", fc_o, 3'b111);
    chk("R3 addr", addr_o, 24'h030000);
    chk("R4 data", data_o, {13'b0, m});
    chk("R5 mask hold", data_o[2:0], m);
    chk("R4 oe", data_oe, 1);
    chk("R6 no early ack", dtack_int, 0);
    @(negedge clk);
    chk("R6 ack", {dtack_int, as_o, ds_o}, 3'b111);
    halt = (hl > 0);
    @(negedge clk);
    chk("R7 strobes off", {as_o, ds_o, dtack_int, bus_req}, 4'b0001);
    @(negedge clk);
    bus_grant = 0;
    chk("R7 release", bus_req, 0); chk("R8 not yet", stop_active, 0);
    for (int i = 0; i < hl; i++) begin
      @(negedge clk); chk("R8 halt hold", stop_active, 0);
    end
    halt = 0;
    @(negedge clk); chk("R8 stop entered", stop_active, 1);
    stop_req = 1; mask = m;
    @(negedge clk); stop_req = 0;
    @(negedge clk);
    chk("R9 ignore req", {stop_active, bus_req, as_o}, 3'b100);
    wake = 1;
    @(negedge clk); wake = 0;
    chk("R9 wake", {stop_active, bus_req}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs", {bus_req, as_o, ds_o, rw_o, fc_o, data_oe, dtack_int, stop_active}, 10'b0001000000);
    chk("R1 addr", addr_o, 0); chk("R1 data", data_o, 0);
    rst = 0;
    for (int m = 0; m < 8; m++)
      for (int g = 0; g < 3; g++)
        for (int h = 0; h < 4; h++)
          run(3'(m), g, h);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule